// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable model of a clocked static RAM that runs four-beat bursts. On any rising clock edge, a caller can hand it a fresh address through one of two strobe inputs. One strobe is meant for a processor and the other for a memory controller. Once a burst is open, each cycle with the advance input high moves to the next word of the burst. The block computes that word's address itself from the starting address, so the external address bus is free during those cycles. Bursts are optional: a caller can also present a new address on every cycle at full rate.

The two lowest address bits form the burst counter. It counts in one of two orders. Linear order adds the beat number modulo four. Interleaved order XORs the starting bits with the beat number. A write can update every byte lane or only the selected lanes. Read data leaves the block in one of two ways. In flow-through mode it bypasses the output register. In pipelined mode it passes through a rising-edge output register, which adds one cycle. When the burst-order and output-mode inputs are both tied high, the block runs interleaved bursts with a pipelined output, which is its default configuration. A cycle with chip enable low is a deselect. It takes effect at once, with no extra pipeline stage.

Top module: `sync_burst_sram`

## Requirements
- R1: While `ce` is high, either `strobe_cpu` or `strobe_ctl` loads `addr` as the access address of that cycle and starts a new burst. A strobe takes priority over `adv`.
- R2: While a burst is open and `ce` is high with no strobe, `adv` high steps to the next beat and ignores `addr`. Address bits above bit 1 stay those of the starting address. After four beats the sequence wraps and repeats the same four words.
- R3: With `burst_il` low, address bits [1:0] of beat k are the starting bits plus k, modulo 4.
- R4: With `burst_il` high, address bits [1:0] of beat k are the starting bits XOR k.
- R5: With `pipe_mode` low, the data of a read whose address is taken at clock edge E appears on `rdata` with `rvalid` high during the cycle after E.
- R6: With `pipe_mode` high, the same read appears one cycle later, in the cycle after edge E+1.
- R7: An access cycle with `gw` high writes all lanes of `wdata`. Otherwise, with `bwe` high, it writes only the lanes whose `bsel` bit is 1, where lane i covers data bits [9i+8:9i]. A write cycle produces no read output.
- R8: A cycle with `ce` low makes no access and writes nothing. It closes any open burst, so a later `adv` does nothing until the next strobe. In flow-through mode `rvalid` is low in the very next cycle.
- R9: Whenever `oe` is low or no read result is due, `rvalid` is 0 and `rdata` is all zeros.
- R10: A cycle with `ce` high, no strobe, and either `adv` low or no open burst makes no access and produces no read result.
- R11: Back-to-back strobes on consecutive cycles each perform a full access, with one read result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | External word address |
| strobe_cpu | input | 1 | Processor-side address strobe |
| strobe_ctl | input | 1 | Controller-side address strobe |
| adv | input | 1 | Advance to the next burst beat |
| ce | input | 1 | Chip enable; low deselects |
| gw | input | 1 | Global write, all lanes |
| bwe | input | 1 | Byte-write enable |
| bsel | input | DATA_W/9 | Byte-lane select for byte writes |
| oe | input | 1 | Output enable |
| burst_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| pipe_mode | input | 1 | Output mode: 1 pipelined, 0 flow-through |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
If the burst counter were wrong, the first stepped beat would return the word from a neighbouring address. That shows up on `rdata` one cycle after the step in flow-through mode, or two cycles after in pipelined mode. To make such a mismatch visible, every word is first filled with data that differs per address. A lost or extra output register shifts every read result by one cycle, so the very next checked read fails. A burst that stays open after a deselect produces an unexpected `rvalid` on the first `adv` that follows. A wrong lane mask leaves foreign bytes in the word read back right after a partial write.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Low two address bits of burst beat `beat` starting from `start`.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       il);
    return il ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen
  import sbs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          load,
  input  logic          adv,
  input  logic          il,
  input  logic [AW-1:0] ext_addr,
  output logic          acc_valid,
  output logic          acc_step,
  output logic [AW-1:0] acc_addr
);

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    beat_q, beat_d, beat_nx;
  logic          open_q, open_d;
  logic          do_load, upd_en;

  assign do_load   = ce & load;
  assign acc_step  = ce & ~load & open_q & adv;
  assign acc_valid = do_load | acc_step;
  assign beat_nx   = beat_q + 2'd1;
  assign upd_en    = ~ce | do_load | acc_step;

  always_comb begin
    base_d   = base_q;
    beat_d   = beat_q;
    open_d   = open_q;
    acc_addr = ext_addr;
    if (!ce) begin
      open_d = 1'b0;
    end else if (load) begin
      base_d = ext_addr;
      beat_d = 2'd0;
      open_d = 1'b1;
    end else if (acc_step) begin
      beat_d   = beat_nx;
      acc_addr = {base_q[AW-1:2], burst_low(base_q[1:0], beat_nx, il)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      open_q <= 1'b0;
    end else if (upd_en) begin
      base_q <= base_d;
      beat_q <= beat_d;
      open_q <= open_d;
    end
  end

endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
  parameter int AW    = 8,
  parameter int LW    = 9,
  parameter int LANES = 4
) (
  input  logic                clk,
  input  logic [LANES-1:0]    wr_mask,
  input  logic [AW-1:0]       wr_addr,
  input  logic [LANES*LW-1:0] wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [LANES*LW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_mask[g]) begin
        store[wr_addr] <= wr_data[g*LW +: LW];
      end
    end

    assign rd_data[g*LW +: LW] = store[rd_addr];
  end

endmodule

// File: rtl/sbs_out_path.sv
module sbs_out_path #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic [AW-1:0] rd_addr_in,
  output logic [AW-1:0] rd_addr_q,
  input  logic [DW-1:0] mem_data,
  input  logic          pipe_mode,
  input  logic          oe,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);

  logic          fv_q, pv_q;
  logic [DW-1:0] pd_q;
  logic          sel_v;
  logic [DW-1:0] sel_d;

  // Address stage: captured only on a read fire.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      fv_q      <= 1'b0;
      pv_q      <= 1'b0;
    end else begin
      fv_q <= rd_fire;
      pv_q <= fv_q;
      if (rd_fire) begin
        rd_addr_q <= rd_addr_in;
      end
    end
  end

  // Output register, loaded only when a flow result exists.
  always_ff @(posedge clk) begin
    if (fv_q) begin
      pd_q <= mem_data;
    end
  end

  always_comb begin
    sel_v = pipe_mode ? pv_q : fv_q;
    sel_d = pipe_mode ? pd_q : mem_data;
    rvalid = oe & sel_v;
    rdata  = rvalid ? sel_d : '0;
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              adv,
  input  logic              ce,
  input  logic              gw,
  input  logic              bwe,
  input  logic [LANES-1:0]  bsel,
  input  logic              oe,
  input  logic              burst_il,
  input  logic              pipe_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic              rs1_q, rs2_q;
  logic              acc_valid, acc_step;
  logic [ADDR_W-1:0] acc_addr;
  logic              is_write, rd_fire;
  logic [LANES-1:0]  wr_mask;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] mem_data;

  // Reset: asserts asynchronously, releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  sbs_burst_gen #(.AW(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rs2_q),
    .ce        (ce),
    .load      (strobe_cpu | strobe_ctl),
    .adv       (adv),
    .il        (burst_il),
    .ext_addr  (addr),
    .acc_valid (acc_valid),
    .acc_step  (acc_step),
    .acc_addr  (acc_addr)
  );

  always_comb begin
    is_write = gw | bwe;
    rd_fire  = acc_valid & ~is_write;
    wr_mask  = '0;
    if (acc_valid) begin
      if (gw)       wr_mask = '1;
      else if (bwe) wr_mask = bsel;
    end
  end

  sbs_lane_mem #(.AW(ADDR_W), .LW(LANE_W), .LANES(LANES)) u_mem (
    .clk     (clk),
    .wr_mask (wr_mask),
    .wr_addr (acc_addr),
    .wr_data (wdata),
    .rd_addr (rd_addr_q),
    .rd_data (mem_data)
  );

  sbs_out_path #(.AW(ADDR_W), .DW(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rs2_q),
    .rd_fire    (rd_fire),
    .rd_addr_in (acc_addr),
    .rd_addr_q  (rd_addr_q),
    .mem_data   (mem_data),
    .pipe_mode  (pipe_mode),
    .oe         (oe),
    .rvalid     (rvalid),
    .rdata      (rdata)
  );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              strobe_cpu,
  input logic              strobe_ctl,
  input logic [ADDR_W-1:0] addr,
  input logic              pipe_mode,
  input logic              rvalid,
  input logic              acc_valid,
  input logic              acc_step,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              burst_il,
  input logic [LANES-1:0]  wr_mask
);

  logic              seen_q, have_q, lin_q;
  logic [ADDR_W-3:0] hi_q;
  logic [1:0]        lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      have_q <= 1'b0;
      lin_q  <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      seen_q <= 1'b1;
      if (acc_valid) begin
        have_q <= 1'b1;
        hi_q   <= acc_addr[ADDR_W-1:2];
        lo_q   <= acc_addr[1:0];
        lin_q  <= acc_step ? ~burst_il : 1'b1;
      end
    end
  end

  p_strobe_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && (strobe_cpu || strobe_ctl)) |-> (acc_valid && acc_addr == addr));

  p_upper_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_step && have_q) |-> (acc_addr[ADDR_W-1:2] == hi_q));

  p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_step && have_q && !burst_il && lin_q) |-> (acc_addr[1:0] == lo_q + 2'd1));

  p_no_write_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> (wr_mask == '0 && !acc_valid));

  p_flow_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(!ce) && !pipe_mode) |-> !rvalid);

endmodule

bind sync_burst_sram sbs_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce         (ce),
  .strobe_cpu (strobe_cpu),
  .strobe_ctl (strobe_ctl),
  .addr       (addr),
  .pipe_mode  (pipe_mode),
  .rvalid     (rvalid),
  .acc_valid  (acc_valid),
  .acc_step   (acc_step),
  .acc_addr   (acc_addr),
  .burst_il   (burst_il),
  .wr_mask    (wr_mask)
);

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;

  localparam int AW    = 8;
  localparam int DW    = 36;
  localparam int LW    = 9;
  localparam int LANES = DW / LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic strobe_cpu, strobe_ctl, adv, ce, gw, bwe, oe, burst_il, pipe_mode;
  logic [LANES-1:0] bsel;
  logic [DW-1:0] wdata, rdata;
  logic rvalid;

  always #2 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strobe_cpu(strobe_cpu),
    .strobe_ctl(strobe_ctl), .adv(adv), .ce(ce), .gw(gw), .bwe(bwe),
    .bsel(bsel), .oe(oe), .burst_il(burst_il), .pipe_mode(pipe_mode),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string ctx = "reset";

  logic [DW-1:0] ref_mem [DEPTH];
  logic          m_open;
  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;
  logic          h1v, h2v;
  logic [DW-1:0] h1d, h2d;

  function automatic logic [1:0] model_low(logic [1:0] s, logic [1:0] k, logic il);
    if (il) return s ^ k;
    return s + k;
  endfunction

  task automatic check_out();
    logic          ev;
    logic [DW-1:0] ed;
    string         tag;
    ev = oe && (pipe_mode ? h2v : h1v);
    ed = ev ? (pipe_mode ? h2d : h1d) : '0;
    tag = !ev ? "R9" : (pipe_mode ? "R6" : "R5");
    checks++;
    if (rvalid !== ev || rdata !== ed) begin
      failures++;
      $display("FAIL %s [%s] rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, ctx, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic cyc(input logic sc, input logic sk, input logic av, input logic c,
                     input logic g, input logic b, input logic [LANES-1:0] bs,
                     input logic o, input logic il, input logic pm,
                     input logic [AW-1:0] ad, input logic [DW-1:0] wd);
    logic ld, st, iv;
    logic [AW-1:0] a;
    logic [DW-1:0] id;
    @(negedge clk);
    check_out();
    strobe_cpu = sc; strobe_ctl = sk; adv = av; ce = c; gw = g; bwe = b;
    bsel = bs; oe = o; burst_il = il; pipe_mode = pm; addr = ad; wdata = wd;
    ld = c && (sc || sk);
    st = c && !ld && m_open && av;
    a = '0; iv = 1'b0; id = '0;
    if (ld) begin
      a = ad; m_base = ad; m_beat = 2'd0; m_open = 1'b1;
    end else if (st) begin
      m_beat = m_beat + 2'd1;
      a = {m_base[AW-1:2], model_low(m_base[1:0], m_beat, il)};
    end
    if (!c) m_open = 1'b0;
    if (ld || st) begin
      if (g || b) begin
        for (int l = 0; l < LANES; l++)
          if (g || bs[l]) ref_mem[a][l*LW +: LW] = wd[l*LW +: LW];
      end else begin
        iv = 1'b1; id = ref_mem[a];
      end
    end
    h2v = h1v; h2d = h1d; h1v = iv; h1d = id;
  endtask

  // Directed burst: one strobed read then n advancing reads.
  task automatic burst_read(input logic il, input logic pm, input logic [AW-1:0] start,
                            input int n, input logic use_ctl);
    cyc(!use_ctl, use_ctl, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b1, il, pm, start, '0);
    for (int i = 0; i < n; i++)
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b1, il, pm, ~start, '0);
  endtask

  task automatic idle(input int n, input logic pm);
    for (int i = 0; i < n; i++)
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1, pm, '0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired in [%s] rvalid=%0b rdata=%h expected completion",
               ctx, rvalid, rdata);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0;
    strobe_cpu = 0; strobe_ctl = 0; adv = 0; ce = 0; gw = 0; bwe = 0;
    bsel = '0; oe = 1; burst_il = 1; pipe_mode = 1; addr = '0; wdata = '0;
    m_open = 0; m_base = '0; m_beat = '0;
    h1v = 0; h2v = 0; h1d = '0; h2d = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    ctx = "reset state R9";
    check_out();
    rst_n = 1'b1;
    idle(4, 1'b1);

    // Fill every word with address-unique data (global writes, R7).
    ctx = "fill with global writes R7 R11";
    for (int i = 0; i < DEPTH; i++)
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b1, 1'b1, 1'b1, AW'(i),
          {AW'(i), AW'(~i), 20'($urandom)});

    ctx = "R3 linear burst with R2 wrap, flow";
    burst_read(1'b0, 1'b0, 8'h25, 6, 1'b0);
    idle(3, 1'b0);
    ctx = "R4 interleaved burst with R2 wrap, pipeline";
    burst_read(1'b1, 1'b1, 8'h37, 6, 1'b1);
    idle(3, 1'b1);
    ctx = "R4 interleaved burst, flow, R1 controller strobe";
    burst_read(1'b1, 1'b0, 8'hC2, 4, 1'b1);
    idle(2, 1'b0);
    ctx = "R3 linear burst, pipeline";
    burst_read(1'b0, 1'b1, 8'h4B, 4, 1'b0);
    idle(2, 1'b1);

    ctx = "R7 byte-lane write then read";
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0101, 1'b1, 1'b1, 1'b0, 8'h10, {4{9'h1AB}});
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 8'h10, '0);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, 8'h10, '1);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 8'h10, '0);
    idle(2, 1'b0);

    ctx = "R8 deselect closes burst, adv ignored";
    burst_read(1'b1, 1'b0, 8'h81, 1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b1, 1'b1, 1'b0, 8'h81, '1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 8'h82, '0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 8'h83, '0);
    ctx = "R10 enabled cycle without strobe or advance";
    burst_read(1'b0, 1'b1, 8'h90, 0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b1, 8'h91, '0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b1, 8'h92, '0);
    idle(3, 1'b1);

    ctx = "R9 output enable low hides reads";
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 8'h20, '0);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 8'h21, '0);
    idle(2, 1'b0);

    ctx = "R11 back-to-back strobes, alternating sides";
    for (int i = 0; i < 16; i++)
      cyc(i[0], !i[0], 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b1, AW'(i * 13), '0);
    idle(2, 1'b1);

    ctx = "R1/R2 random mix";
    begin
      logic il_r, pm_r;
      il_r = 1'b1; pm_r = 1'b1;
      for (int i = 0; i < 4000; i++) begin
        logic s, wr;
        if ((i % 64) == 0) begin
          il_r = 1'($urandom); pm_r = 1'($urandom);
        end
        s  = ($urandom % 10) < 3;
        wr = ($urandom % 10) < 3;
        cyc(s && 1'($urandom), s && 1'($urandom), ($urandom % 2) == 0,
            ($urandom % 10) != 0, wr && (($urandom % 3) == 0), wr,
            LANES'($urandom), ($urandom % 8) != 0, il_r, pm_r,
            AW'($urandom), {4'($urandom), 32'($urandom)});
      end
    end
    idle(3, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule